// File: doc/BRIEF.md
# Circular Command Queue Engine

The engine drains a ring of 32-byte command records held in system memory. Software places records in the ring, then moves a write offset past them. Whenever the unit is enabled and the write offset differs from its own read offset, the engine reads the first doubleword of the record at the read offset. It takes the command code from the low byte and either hands the record to an external handler or completes it on the spot. When a record finishes cleanly, the read offset moves forward and wraps at the ring capacity. A failed memory read, or a handler that reports an error, freezes the engine with a sticky stall flag instead.

Ring geometry comes from a configuration write, which is accepted only while the unit is disabled. That write carries a 4 KiB-aligned base and a page-count field, and the capacity in records is computed from the page count at run time. If either offset lies beyond the capacity, the engine stops without touching memory. Command semantics are outside this block: a handler receives the code and the record address and answers with a done pulse and an error flag.

Top module: `cmdq_engine`

## Requirements
- R1: After reset the read offset, the write offset and the stall flag are zero, and neither the memory request nor the handler request is asserted.
- R2: Records are consumed only while `enable` is high. Each pass repeats until the read offset equals the write offset. While `enable` is low, no memory fetch is issued.
- R3: A write-offset update (`wrOffWe`) starts processing. If the new value differs from the read offset, `memReq` rises two clock edges after the edge that loads it.
- R4: The fetch address is `cfgBase`×4096 + read offset×32. `memReq` is held until `memAck`. The handler sees the low 8 bits of the fetched doubleword on `hCode` and the record address on `hAddr`.
- R5: Capacity in records is (`cfgPages`+1)×128. After each clean completion the read offset becomes (read offset + 1) modulo capacity, so the entry at capacity−1 wraps to 0.
- R6: If the read offset or the write offset is strictly greater than the capacity, processing stops with no fetch, no stall, and no change to the read offset.
- R7: A fetch that returns `memErr`, or a handler completion with `hErr`, sets the stall flag, leaves the read offset unchanged and ends processing.
- R8: The stall flag is sticky. While it is set, further write-offset updates start no fetch and do not move the read offset.
- R9: A rising edge of `enable` sets the read offset to zero and starts processing from there.
- R10: Code 8'h05 (synchronize) and any code outside the handled set {8'h03, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0F} complete without a handler request and advance the read offset. Codes in the set raise `hReq` until `hDone`.
- R11: A configuration write (`cfgWe`) while disabled loads base and page count, zeroes both offsets and clears the stall flag. While enabled, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable; rising edge restarts the ring at offset 0 |
| cfgWe | input | 1 | Configuration (queue reset) write strobe |
| cfgBase | input | ADDR_W-12 | Ring base in 4 KiB pages |
| cfgPages | input | SIZE_W | Ring size in pages minus one |
| wrOffWe | input | 1 | Write-offset update strobe |
| wrOffIn | input | OFF_W | New write offset, in records |
| rdOff | output | OFF_W | Current read offset, in records |
| wrOff | output | OFF_W | Current write offset, in records |
| stalled | output | 1 | Sticky failure flag |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | ADDR_W | Byte address of the record being fetched |
| memAck | input | 1 | Memory read completion pulse |
| memData | input | DATA_W | First doubleword of the record |
| memErr | input | 1 | Memory read failure, valid with memAck |
| hReq | output | 1 | Handler request, held until hDone |
| hCode | output | 8 | Command code of the current record |
| hAddr | output | ADDR_W | Byte address of the current record |
| hDone | input | 1 | Handler completion pulse |
| hErr | input | 1 | Handler failure, valid with hDone |

## Verification
Only the first fetch after a write-offset update has a fixed latency of two edges. The bench samples `memReq` on the falling edges after the first and the second rising edge to pin it down exactly. Every other result depends on memory and handler response times, so after each stimulus the bench waits a window longer than the worst-case cycles for the batch it issued. It then samples offsets, stall flag and the handler and fetch logs at a falling edge. Where the expected result is that nothing happens (disabled unit, stall, out-of-range offsets), the logged fetch count must stay where it was.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int PAGE_LOG2  = 12;
  localparam int ENTRY_LOG2 = 5;
  localparam int SLOTS_LOG2 = PAGE_LOG2 - ENTRY_LOG2;
  localparam int CODE_W     = 8;

  localparam logic [CODE_W-1:0] CODE_SYNC = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_DISPATCH,
    ST_STEP
  } engState_t;

  typedef struct packed {
    logic loadCfg;
    logic loadWr;
    logic zeroRd;
    logic advance;
    logic setStall;
    logic latchCode;
  } dpStrobe_t;

  function automatic logic needsHandler(input logic [CODE_W-1:0] code);
    case (code)
      8'h03, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 8,
  localparam int OFF_W  = SIZE_W + SLOTS_LOG2 + 1,
  localparam int BASE_W = ADDR_W - PAGE_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         str,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [SIZE_W-1:0] cfgPages,
  input  logic [OFF_W-1:0]  wrOffIn,
  input  logic [CODE_W-1:0] fetchedCode,
  output logic [OFF_W-1:0]  rdOff,
  output logic [OFF_W-1:0]  wrOff,
  output logic              stalled,
  output logic [ADDR_W-1:0] entryAddr,
  output logic [CODE_W-1:0] cmdCode,
  output logic              offsEqual,
  output logic              rangeBad,
  output logic              needsWork
);

  logic [BASE_W-1:0] baseQ;
  logic [SIZE_W-1:0] pagesQ;
  logic [OFF_W-1:0]  pagesExt;
  logic [OFF_W-1:0]  capacity;
  logic [OFF_W:0]    incr;
  logic [OFF_W-1:0]  rdNext;

  assign pagesExt = OFF_W'(pagesQ) + OFF_W'(1);
  assign capacity = pagesExt << SLOTS_LOG2;

  assign incr   = {1'b0, rdOff} + (OFF_W+1)'(1);
  assign rdNext = (incr >= {1'b0, capacity}) ? OFF_W'(incr - {1'b0, capacity})
                                             : incr[OFF_W-1:0];

  assign entryAddr = {baseQ, {PAGE_LOG2{1'b0}}} + (ADDR_W'(rdOff) << ENTRY_LOG2);

  assign offsEqual = (rdOff == wrOff);
  assign rangeBad  = (rdOff > capacity) || (wrOff > capacity);
  assign needsWork = needsHandler(cmdCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      pagesQ  <= '0;
      rdOff   <= '0;
      wrOff   <= '0;
      stalled <= 1'b0;
      cmdCode <= '0;
    end else begin
      if (str.loadCfg) begin
        baseQ   <= cfgBase;
        pagesQ  <= cfgPages;
        rdOff   <= '0;
        wrOff   <= '0;
        stalled <= 1'b0;
      end else begin
        if (str.loadWr) wrOff <= wrOffIn;
        if (str.zeroRd) rdOff <= '0;
        else if (str.advance) rdOff <= rdNext;
        if (str.setStall) stalled <= 1'b1;
      end
      if (str.latchCode) cmdCode <= fetchedCode;
    end
  end

  // R8
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && !str.loadCfg) |=> stalled);

  // R7
  stall_rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.setStall && !str.zeroRd && !str.loadCfg) |=> (rdOff == $past(rdOff)));

  // R5
  wrap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.advance && !str.zeroRd && !str.loadCfg) |=> (rdOff < capacity));

endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      cfgWe,
  input  logic      wrOffWe,
  input  logic      offsEqual,
  input  logic      rangeBad,
  input  logic      stalled,
  input  logic      needsWork,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      hDone,
  input  logic      hErr,
  output dpStrobe_t str,
  output logic      memReq,
  output logic      hReq
);

  engState_t state, nextState;
  logic enPrev;
  logic kick;
  logic enRise;

  assign enRise = enable && !enPrev;

  always_comb begin
    str         = '0;
    str.loadCfg = cfgWe && !enable;
    str.loadWr  = wrOffWe;
    str.zeroRd  = enRise;
    nextState   = state;
    memReq      = 1'b0;
    hReq        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (kick && enable && !stalled) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (!enable || stalled || offsEqual || rangeBad) nextState = ST_IDLE;
        else nextState = ST_FETCH;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            str.setStall = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            str.latchCode = 1'b1;
            nextState     = ST_DISPATCH;
          end
        end
      end
      ST_DISPATCH: begin
        if (needsWork) begin
          hReq = 1'b1;
          if (hDone) begin
            if (hErr) begin
              str.setStall = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              nextState = ST_STEP;
            end
          end
        end else begin
          nextState = ST_STEP;
        end
      end
      ST_STEP: begin
        str.advance = 1'b1;
        nextState   = ST_CHECK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enPrev <= 1'b0;
      kick   <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enable;
      if (wrOffWe || enRise) kick <= 1'b1;
      else if (state == ST_IDLE && nextState == ST_CHECK) kick <= 1'b0;
    end
  end

  // R6
  range_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && rangeBad) |=> !memReq);

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !enable) |=> !memReq);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R10
  handler_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hReq && !hDone) |=> hReq);

endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 8,
  parameter int DATA_W = 64,
  localparam int OFF_W  = SIZE_W + SLOTS_LOG2 + 1,
  localparam int BASE_W = ADDR_W - PAGE_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgWe,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [SIZE_W-1:0] cfgPages,
  input  logic              wrOffWe,
  input  logic [OFF_W-1:0]  wrOffIn,
  output logic [OFF_W-1:0]  rdOff,
  output logic [OFF_W-1:0]  wrOff,
  output logic              stalled,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr,
  output logic              hReq,
  output logic [CODE_W-1:0] hCode,
  output logic [ADDR_W-1:0] hAddr,
  input  logic              hDone,
  input  logic              hErr
);

  dpStrobe_t         str;
  logic              offsEqual;
  logic              rangeBad;
  logic              needsWork;
  logic [ADDR_W-1:0] entryAddr;
  logic [CODE_W-1:0] cmdCode;
  logic              unusedHigh;

  assign unusedHigh = ^memData[DATA_W-1:CODE_W];

  cmdq_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .cfgWe     (cfgWe),
    .wrOffWe   (wrOffWe),
    .offsEqual (offsEqual),
    .rangeBad  (rangeBad),
    .stalled   (stalled),
    .needsWork (needsWork),
    .memAck    (memAck),
    .memErr    (memErr),
    .hDone     (hDone),
    .hErr      (hErr),
    .str       (str),
    .memReq    (memReq),
    .hReq      (hReq)
  );

  cmdq_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .cfgBase     (cfgBase),
    .cfgPages    (cfgPages),
    .wrOffIn     (wrOffIn),
    .fetchedCode (memData[CODE_W-1:0]),
    .rdOff       (rdOff),
    .wrOff       (wrOff),
    .stalled     (stalled),
    .entryAddr   (entryAddr),
    .cmdCode     (cmdCode),
    .offsEqual   (offsEqual),
    .rangeBad    (rangeBad),
    .needsWork   (needsWork)
  );

  assign memAddr = entryAddr;
  assign hAddr   = entryAddr;
  assign hCode   = cmdCode;

endmodule

// File: tb/cmdq_engine_test.sv
module cmdq_engine_test;

  localparam int ADDR_W = 48;
  localparam int SIZE_W = 8;
  localparam int DATA_W = 64;
  localparam int OFF_W  = 16;
  localparam int BASE_W = 36;
  localparam logic [63:0] BASE_BYTES = 64'h1000;

  // {code, handler expected}
  localparam logic [8:0] VEC [8] = '{
    {8'h03, 1'b1}, {8'h05, 1'b0}, {8'h08, 1'b1}, {8'h77, 1'b0},
    {8'h0F, 1'b1}, {8'h0C, 1'b1}, {8'h05, 1'b0}, {8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic cfgWe = 1'b0;
  logic [BASE_W-1:0] cfgBase = '0;
  logic [SIZE_W-1:0] cfgPages = '0;
  logic wrOffWe = 1'b0;
  logic [OFF_W-1:0] wrOffIn = '0;
  logic [OFF_W-1:0] rdOff, wrOff;
  logic stalled, memReq, hReq;
  logic [ADDR_W-1:0] memAddr, hAddr;
  logic [7:0] hCode;
  logic memAck = 1'b0;
  logic [DATA_W-1:0] memData = '0;
  logic memErr = 1'b0;
  logic hDone = 1'b0;
  logic hErr = 1'b0;

  logic [7:0] memCode [64];
  logic       memBad  [64];
  logic       hBad    [64];
  int fetchCnt = 0;
  int dispCnt  = 0;
  logic [7:0]  lastCode = '0;
  logic [63:0] lastAddr = '0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cmdq_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .cfgBase(cfgBase),
    .cfgPages(cfgPages), .wrOffWe(wrOffWe), .wrOffIn(wrOffIn), .rdOff(rdOff),
    .wrOff(wrOff), .stalled(stalled), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .memErr(memErr), .hReq(hReq),
    .hCode(hCode), .hAddr(hAddr), .hDone(hDone), .hErr(hErr)
  );

  // memory and handler responders, one cycle each
  always @(posedge clk) begin
    memAck  <= memReq && !memAck;
    memData <= {56'hA5A5_0000_1234_56, memCode[memAddr[10:5]]};
    memErr  <= memBad[memAddr[10:5]];
    hDone   <= hReq && !hDone;
    hErr    <= hBad[hAddr[10:5]];
    if (memReq && memAck) fetchCnt <= fetchCnt + 1;
    if (hReq && hDone) begin
      dispCnt  <= dispCnt + 1;
      lastCode <= hCode;
      lastAddr <= 64'(hAddr);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeWr(input int v);
    @(negedge clk);
    wrOffIn = OFF_W'(v);
    wrOffWe = 1'b1;
    @(negedge clk);
    wrOffWe = 1'b0;
  endtask

  task automatic cfgWrite(input int pages);
    @(negedge clk);
    cfgBase  = BASE_W'(1);
    cfgPages = SIZE_W'(pages);
    cfgWe    = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pos;
    int d0;
    int f0;
    for (int i = 0; i < 64; i++) begin
      memCode[i] = 8'h05;
      memBad[i]  = 1'b0;
      hBad[i]    = 1'b0;
    end
    settle(3);
    rstN = 1'b1;
    settle(1);
    // R1 reset state
    chk("R1 rdOff", 64'(rdOff), 0);
    chk("R1 wrOff", 64'(wrOff), 0);
    chk("R1 stalled", 64'(stalled), 0);
    chk("R1 memReq", 64'(memReq), 0);
    chk("R1 hReq", 64'(hReq), 0);

    cfgWrite(0);
    enable = 1'b1;
    settle(5);

    // R3 first fetch exactly two edges after the write-offset load
    @(negedge clk);
    wrOffIn = OFF_W'(1);
    wrOffWe = 1'b1;
    @(negedge clk);
    wrOffWe = 1'b0;
    chk("R3 memReq after 0 edges", 64'(memReq), 0);
    @(negedge clk);
    chk("R3 memReq after 1 edge", 64'(memReq), 0);
    @(negedge clk);
    chk("R3 memReq after 2 edges", 64'(memReq), 1);
    chk("R4 fetch address entry 0", 64'(memAddr), BASE_BYTES);
    settle(20);
    chk("R2 rdOff after one record", 64'(rdOff), 1);
    pos = 1;

    // table-driven single records: R4 R10
    for (int i = 0; i < 8; i++) begin
      memCode[pos] = VEC[i][8:1];
      d0 = dispCnt;
      writeWr(pos + 1);
      settle(20);
      chk("R5 rdOff increments", 64'(rdOff), 64'(pos + 1));
      chk("R10 handler dispatch count", 64'(dispCnt - d0), 64'(VEC[i][0]));
      if (VEC[i][0]) begin
        chk("R4 hCode low byte", 64'(lastCode), 64'(VEC[i][8:1]));
        chk("R4 hAddr", lastAddr, BASE_BYTES + 64'(pos * 32));
      end
      pos++;
    end

    // R2 batch of five records drained in one pass
    memCode[pos]     = 8'h03;
    memCode[pos + 1] = 8'h05;
    memCode[pos + 2] = 8'h04;
    memCode[pos + 3] = 8'h09;
    memCode[pos + 4] = 8'h55;
    d0 = dispCnt;
    writeWr(pos + 5);
    settle(60);
    chk("R2 batch rdOff", 64'(rdOff), 64'(pos + 5));
    chk("R2 batch dispatches", 64'(dispCnt - d0), 3);
    pos = pos + 5;

    // R7 memory failure stalls
    memCode[pos] = 8'h03;
    memBad[pos]  = 1'b1;
    d0 = dispCnt;
    writeWr(pos + 2);
    settle(40);
    chk("R7 stalled on memErr", 64'(stalled), 1);
    chk("R7 rdOff unchanged", 64'(rdOff), 64'(pos));
    chk("R7 no dispatch", 64'(dispCnt - d0), 0);

    // R8 sticky stall blocks a new write-offset update
    memBad[pos] = 1'b0;
    f0 = fetchCnt;
    writeWr(pos + 3);
    settle(40);
    chk("R8 still stalled", 64'(stalled), 1);
    chk("R8 rdOff unchanged", 64'(rdOff), 64'(pos));
    chk("R8 no fetch", 64'(fetchCnt - f0), 0);

    // R11 configuration write ignored while enabled
    cfgWrite(1);
    chk("R11 ignored when enabled: stalled", 64'(stalled), 1);
    chk("R11 ignored when enabled: wrOff", 64'(wrOff), 64'(pos + 3));

    enable = 1'b0;
    settle(3);
    cfgWrite(1);
    chk("R11 reset rdOff", 64'(rdOff), 0);
    chk("R11 reset wrOff", 64'(wrOff), 0);
    chk("R11 reset stall", 64'(stalled), 0);

    // R7 handler error stalls
    memCode[0] = 8'h03;
    hBad[0] = 1'b1;
    enable = 1'b1;
    settle(5);
    writeWr(1);
    settle(40);
    chk("R7 stalled on hErr", 64'(stalled), 1);
    chk("R7 rdOff unchanged on hErr", 64'(rdOff), 0);

    // R5 wrap at capacity 128
    enable = 1'b0;
    hBad[0] = 1'b0;
    for (int i = 0; i < 64; i++) memCode[i] = 8'h05;
    settle(3);
    cfgWrite(0);
    enable = 1'b1;
    settle(5);
    writeWr(127);
    settle(1500);
    chk("R5 rdOff at 127", 64'(rdOff), 127);
    writeWr(0);
    settle(40);
    chk("R5 rdOff wrapped", 64'(rdOff), 0);

    // R2 disabled: no fetch; R9 enable restart from 0
    writeWr(3);
    settle(60);
    chk("R2 rdOff 3", 64'(rdOff), 3);
    enable = 1'b0;
    settle(5);
    f0 = fetchCnt;
    writeWr(6);
    settle(40);
    chk("R2 disabled rdOff", 64'(rdOff), 3);
    chk("R2 disabled fetches", 64'(fetchCnt - f0), 0);
    enable = 1'b1;
    settle(80);
    chk("R9 restart rdOff", 64'(rdOff), 6);
    chk("R9 restart fetches from 0", 64'(fetchCnt - f0), 6);

    // R6 write offset beyond capacity
    f0 = fetchCnt;
    writeWr(200);
    settle(40);
    chk("R6 rdOff unchanged", 64'(rdOff), 6);
    chk("R6 no fetch", 64'(fetchCnt - f0), 0);
    chk("R6 no stall", 64'(stalled), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule